// File: doc/BRIEF.md
# Status Register with Write Protection

This block keeps the eight-bit status register of a serial nonvolatile memory together with its write-enable latch. A command decoder upstream does all serial shifting and hands the block single-cycle strobes: set the latch, clear the latch, a complete write-status data byte, a recognised memory-write command, and the cycle in which chip select returns high. The block also watches the level of the write-protect pin.

From this it produces three things. The first is the status byte that a read-status command returns. The second is a flag that says whether the status register may be written now. The third is a flag that says whether a memory write to the address on `mem_addr` may proceed. The persistent bits are ordinary flops with a reset value of zero.

A write-status or memory-write command only counts once chip select rises to end it. That same edge drops the write-enable latch.

Top module: `wps_status_top`

## Requirements
- R1: After synchronous reset, `status_out` reads 0x00, and both `sr_write_ok` and `mem_write_ok` are 0.
- R2: `status_out` is laid out as {protect-enable bit 7, spare bits 6:4, block-protect bits 3:2, write-enable latch bit 1, bit 0}. Bit 0 always reads 0.
- R3: `set_en` sets the latch and `clr_en` clears it, both visible one clock later. When both arrive in the same cycle, the clear wins.
- R4: When a write-status command is committed, data bits 7:2 replace status bits 7:2. Data bits 1:0 have no effect on the latch or on bit 0.
- R5: A `cs_rise` that ends a pending write-status or memory-write command clears the latch one clock later. This clear wins over a `set_en` in the same cycle. A `cs_rise` with nothing pending leaves the latch unchanged.
- R6: While the latch is 0, `sr_write_ok` and `mem_write_ok` are 0, and a write-status command leaves the register unchanged.
- R7: When bit 7 is 1 and `wp_level` is 0, `sr_write_ok` is 0. A write-status command that ends in that state leaves bits 7:2 unchanged but still clears the latch.
- R8: Block-protect value 00 protects no address. Value 01 protects addresses whose two top bits are 11. Value 10 protects addresses whose top bit is 1. Value 11 protects every address. `mem_write_ok` is 0 for a protected address.
- R9: A write-status byte has no effect until `cs_rise` ends the command. Spare bits 6:4 are written and read back like the other stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_en | input | 1 | Strobe: set the write-enable latch |
| clr_en | input | 1 | Strobe: clear the write-enable latch |
| wrsr_stb | input | 1 | Strobe: write-status data byte received |
| wrsr_data | input | 8 | Write-status data byte, valid with `wrsr_stb` |
| write_stb | input | 1 | Strobe: memory-write command recognised |
| cs_rise | input | 1 | Strobe: chip select returned high |
| wp_level | input | 1 | Level of the write-protect pin (1 = high) |
| mem_addr | input | ADDR_W | Address of the memory write under consideration |
| status_out | output | 8 | Readable status byte |
| sr_write_ok | output | 1 | Status register may be written |
| mem_write_ok | output | 1 | Memory write to `mem_addr` may proceed |

## Verification
Every stored bit, and so `status_out`, changes at the first rising edge that samples a strobe. `sr_write_ok` and `mem_write_ok` follow combinationally from that stored state and the current `wp_level` and `mem_addr`.

The driver raises inputs at a falling edge. After the next rising edge it queues the expected byte and flags, worked out from the requirements. The monitor compares them 2 ns after that same rising edge, before any input moves again, so every result is read exactly one register stage after its stimulus.

// File: rtl/wps_pkg.sv
// Package: shared constants and the block-protect encoding for the
// status-register block. Assumes an 8-bit status byte.
package wps_pkg;
    localparam int SR_W      = 8;
    localparam int STORE_LSB = 2;          // lowest stored persistent bit
    localparam int STORE_W   = SR_W - STORE_LSB;
    localparam int PEN_BIT   = 7;          // protect-enable position
    localparam int BP_LSB    = 2;          // block-protect field position

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_e;
endpackage

// File: rtl/wps_cmd_track.sv
// Command tracker: remembers whether a write-status or memory-write
// command is open in the current selection and holds the status data byte.
// Assumes strobes are single-cycle. A strobe that arrives in the same cycle
// as cs_rise counts as part of the command that cs_rise ends.
module wps_cmd_track
    import wps_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wrsr_stb,
    input  logic [STORE_W-1:0] wrsr_hi,
    input  logic               write_stb,
    input  logic               cs_rise,
    output logic               end_cmd,
    output logic               commit_sr,
    output logic [STORE_W-1:0] staged
);
    logic               pend_sr;
    logic               pend_wr;
    logic [STORE_W-1:0] data_q;
    logic               sr_now;

    // Purpose: decide whether this chip-select edge closes a command.
    always_comb begin
        sr_now    = pend_sr | wrsr_stb;
        end_cmd   = cs_rise & (sr_now | pend_wr | write_stb);
        commit_sr = cs_rise & sr_now;
        staged    = wrsr_stb ? wrsr_hi : data_q;
    end

    // Purpose: open commands on their strobes and close all at cs_rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sr <= 1'b0;
            pend_wr <= 1'b0;
            data_q  <= '0;
        end else if (cs_rise) begin
            pend_sr <= 1'b0;
            pend_wr <= 1'b0;
        end else begin
            if (wrsr_stb) begin
                pend_sr <= 1'b1;
                data_q  <= wrsr_hi;
            end
            if (write_stb) pend_wr <= 1'b1;
        end
    end

    // R5: no command stays open past the edge that ends a selection.
    assert_cs_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (!pend_sr && !pend_wr));
    // R9: a data byte without cs_rise leaves a pending write-status behind.
    assert_byte_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_stb && !cs_rise) |=> pend_sr);
endmodule

// File: rtl/wps_wel_latch.sv
// Write-enable latch: set and cleared by command strobes, and dropped when
// a write command ends. Assumes end_cmd already includes the cs_rise
// qualification. Priority: command end, then clear, then set.
module wps_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic end_cmd,
    output logic wel
);
    // Purpose: update the latch with its fixed priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (end_cmd) wel <= 1'b0;
        else if (clr_en)  wel <= 1'b0;
        else if (set_en)  wel <= 1'b1;
    end

    // R3: an uncontested set turns the latch on.
    assert_wel_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en && !end_cmd) |=> wel);
    // R3: a clear always turns the latch off.
    assert_wel_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !wel);
    // R5: the end of a write command turns the latch off.
    assert_wel_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |=> !wel);
endmodule

// File: rtl/wps_nv_bits.sv
// Persistent status bits 7:2, modelled as flops with a zero reset value.
// They load only when a commit arrives and the top grants permission.
// Assumes allow already folds in the latch and the pin gate.
module wps_nv_bits
    import wps_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               allow,
    input  logic [STORE_W-1:0] wr_data,
    output logic [STORE_W-1:0] bits
);
    // Purpose: take a new value only on a permitted commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                bits <= '0;
        else if (commit && allow)  bits <= wr_data;
    end

    // R6/R7: a refused commit leaves every stored bit as it was.
    assert_refused_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !allow) |=> $stable(bits));
    // R9: nothing changes without a commit.
    assert_no_commit_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(bits));
endmodule

// File: rtl/wps_prot_decode.sv
// Block-protect decoder: says whether an address lies in the region that
// the two protect bits select. Assumes ADDR_W >= 2.
module wps_prot_decode
    import wps_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int TOP = ADDR_W - 1;

    // Purpose: compare the address top bits against the selected region.
    always_comb begin
        unique case (prot_e'(bp))
            PROT_NONE:    prot = 1'b0;
            PROT_QUARTER: prot = &addr[TOP -: 2];
            PROT_HALF:    prot = addr[TOP];
            PROT_ALL:     prot = 1'b1;
            default:      prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/wps_status_top.sv
// Status register with write protection. Ties the command tracker, the
// write-enable latch, the persistent bits and the protect decoder together.
// Assumes strobes come from an upstream decoder, one cycle each.
module wps_status_top
    import wps_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic              wrsr_stb,
    input  logic [SR_W-1:0]   wrsr_data,
    input  logic              write_stb,
    input  logic              cs_rise,
    input  logic              wp_level,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [SR_W-1:0]   status_out,
    output logic              sr_write_ok,
    output logic              mem_write_ok
);
    logic               end_cmd;
    logic               commit_sr;
    logic [STORE_W-1:0] staged;
    logic [STORE_W-1:0] nv;
    logic               wel;
    logic               prot;
    logic               pin_lock;
    logic               unused_low;

    // Purpose: the two low data bits have no storage behind them.
    assign unused_low = ^wrsr_data[STORE_LSB-1:0];

    wps_cmd_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrsr_stb  (wrsr_stb),
        .wrsr_hi   (wrsr_data[SR_W-1:STORE_LSB]),
        .write_stb (write_stb),
        .cs_rise   (cs_rise),
        .end_cmd   (end_cmd),
        .commit_sr (commit_sr),
        .staged    (staged)
    );

    wps_wel_latch u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .end_cmd (end_cmd),
        .wel     (wel)
    );

    // Purpose: the pin gate and the resulting status-write permission.
    always_comb begin
        pin_lock    = nv[PEN_BIT-STORE_LSB] & ~wp_level;
        sr_write_ok = wel & ~pin_lock;
    end

    wps_nv_bits u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit_sr),
        .allow   (sr_write_ok),
        .wr_data (staged),
        .bits    (nv)
    );

    wps_prot_decode #(.ADDR_W(ADDR_W)) u_prot (
        .bp   (nv[BP_LSB-STORE_LSB +: 2]),
        .addr (mem_addr),
        .prot (prot)
    );

    // Purpose: assemble the readable byte and the memory-write permission.
    always_comb begin
        status_out   = {nv, wel, 1'b0};
        mem_write_ok = wel & ~prot;
    end

    // R2: bit 0 never reads as 1.
    assert_bit0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[0] == 1'b0);
    // R6: no permission at all while the latch is off.
    assert_no_wel_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !status_out[1] |-> (!sr_write_ok && !mem_write_ok));
    // R7: a set protect bit with the pin low blocks status writes.
    assert_pin_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_out[PEN_BIT] && !wp_level) |-> !sr_write_ok);
    // R8: full-array protection refuses every memory write.
    assert_full_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_out[3:2] == 2'b11) |-> !mem_write_ok);
endmodule

// File: tb/wps_status_top_tb_top.sv
// Scoreboard bench: the driver predicts results from the requirements and
// queues them; the monitor compares them after each rising edge.
module wps_status_top_tb_top;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_en = 0, clr_en = 0, wrsr_stb = 0, write_stb = 0, cs_rise = 0;
    logic [7:0]    wrsr_data = '0;
    logic          wp_level = 1'b1;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    status_out;
    logic          sr_write_ok, mem_write_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      req;
        logic [7:0] st;
        logic       sok;
        logic       mok;
    } exp_t;
    exp_t q[$];

    // model state
    logic [5:0] m_bits = '0;
    logic       m_wel = 0, m_psr = 0, m_pwr = 0;
    logic [5:0] m_d = '0;

    always #5 clk = ~clk;

    wps_status_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
        .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data), .write_stb(write_stb),
        .cs_rise(cs_rise), .wp_level(wp_level), .mem_addr(mem_addr),
        .status_out(status_out), .sr_write_ok(sr_write_ok),
        .mem_write_ok(mem_write_ok)
    );

    function automatic logic prot_of(logic [1:0] bp, logic [AW-1:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 13'd6144;
            2'b10:   return a >= 13'd4096;
            default: return 1'b1;
        endcase
    endfunction

    task automatic cmp(string req, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    // Driver: called at a falling edge; drives one cycle and queues the result.
    task automatic cyc(bit se, bit ce, bit sr, logic [7:0] d, bit wr, bit cr,
                       bit wpl, logic [AW-1:0] a, string req);
        logic allow, sr_now;
        logic [5:0] dd;
        exp_t e;
        set_en = se; clr_en = ce; wrsr_stb = sr; wrsr_data = d;
        write_stb = wr; cs_rise = cr; wp_level = wpl; mem_addr = a;
        allow  = m_wel && !(m_bits[5] && !wpl);
        sr_now = m_psr | sr;
        dd     = sr ? d[7:2] : m_d;
        if (cr && (sr_now || m_pwr || wr)) begin
            if (sr_now && allow) m_bits = dd;
            m_wel = 0;
        end else if (ce) m_wel = 0;
        else if (se)     m_wel = 1;
        if (cr) begin
            m_psr = 0; m_pwr = 0;
        end else begin
            if (sr) begin m_psr = 1; m_d = d[7:2]; end
            if (wr) m_pwr = 1;
        end
        @(posedge clk);
        e.req = req;
        e.st  = {m_bits, m_wel, 1'b0};
        e.sok = m_wel & ~(m_bits[5] & ~wpl);
        e.mok = m_wel & ~prot_of(m_bits[1:0], a);
        q.push_back(e);
        @(negedge clk);
        set_en = 0; clr_en = 0; wrsr_stb = 0; write_stb = 0; cs_rise = 0;
    endtask

    // Monitor: compare queued predictions 2 ns after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            cmp(e.req, "status", status_out, e.st);
            cmp(e.req, "sr_ok", {7'd0, sr_write_ok}, {7'd0, e.sok});
            cmp(e.req, "mem_ok", {7'd0, mem_write_ok}, {7'd0, e.mok});
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        cmp("R1", "status", status_out, 8'h00);
        cmp("R1", "sr_ok", {7'd0, sr_write_ok}, 8'h00);
        cmp("R1", "mem_ok", {7'd0, mem_write_ok}, 8'h00);
        @(negedge clk);
        // R6: without the latch nothing is written
        cyc(0,0,1,8'hFC,0,1,1,13'h0000,"R6");
        // R3: set, clear, set+clear
        cyc(1,0,0,8'h00,0,0,1,13'h0010,"R3");
        cyc(0,1,0,8'h00,0,0,1,13'h0010,"R3");
        cyc(1,1,0,8'h00,0,0,1,13'h0010,"R3");
        // R9: byte alone does nothing until cs_rise
        cyc(1,0,0,8'h00,0,0,1,13'h0000,"R3");
        cyc(0,0,1,8'hFF,0,0,1,13'h0000,"R9");
        cyc(0,0,0,8'h00,0,0,1,13'h0000,"R9");
        // R4/R5/R2: commit 0xFF -> 0xFC, latch dropped
        cyc(0,0,0,8'h00,0,1,1,13'h0000,"R4");
        // R9: spare bits written and read back
        cyc(1,0,0,8'h00,0,0,1,13'h0000,"R3");
        cyc(0,0,1,8'h70,0,1,1,13'h0000,"R9");
        // R5: cs_rise with nothing pending keeps the latch
        cyc(1,0,0,8'h00,0,0,1,13'h0000,"R3");
        cyc(0,0,0,8'h00,0,1,1,13'h0000,"R5");
        // R5: memory write command ends -> latch dropped, set loses
        cyc(0,0,0,8'h00,1,0,1,13'h0000,"R5");
        cyc(1,0,0,8'h00,0,1,1,13'h0000,"R5");
        // R8: quarter protection
        cyc(1,0,0,8'h00,0,0,1,13'h0000,"R3");
        cyc(0,0,1,8'h04,0,1,1,13'h0000,"R4");
        cyc(1,0,0,8'h00,0,0,1,13'h17FF,"R8");
        cyc(0,0,0,8'h00,0,0,1,13'h1800,"R8");
        cyc(0,0,0,8'h00,0,0,1,13'h1FFF,"R8");
        // R8: half protection
        cyc(0,0,1,8'h08,0,1,1,13'h0000,"R4");
        cyc(1,0,0,8'h00,0,0,1,13'h0FFF,"R8");
        cyc(0,0,0,8'h00,0,0,1,13'h1000,"R8");
        // R8: full protection
        cyc(0,0,1,8'h0C,0,1,1,13'h0000,"R4");
        cyc(1,0,0,8'h00,0,0,1,13'h0000,"R8");
        // R8: none
        cyc(0,0,1,8'h00,0,1,1,13'h0000,"R4");
        cyc(1,0,0,8'h00,0,0,1,13'h1FFF,"R8");
        // R7: protect bit with pin low
        cyc(0,0,1,8'h80,0,1,1,13'h0000,"R4");
        cyc(1,0,0,8'h00,0,0,0,13'h0000,"R7");
        cyc(0,0,1,8'h00,0,1,0,13'h0000,"R7");
        cyc(1,0,0,8'h00,0,0,1,13'h0000,"R7");
        cyc(0,0,1,8'h00,0,1,1,13'h0000,"R7");
        // R4: low data bits do not touch latch or bit 0
        cyc(1,0,0,8'h00,0,0,1,13'h0000,"R3");
        cyc(0,0,1,8'h03,0,1,1,13'h0000,"R4");
        cyc(0,0,0,8'h00,0,0,1,13'h0000,"R2");
        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule